// File: doc/BRIEF.md
# Comparator Output Majority Filter

This block cleans up the one-bit decision of a sampled comparator by taking one sample on every sampling-clock cycle and voting over a short window of recent samples. The window size is chosen at run time. The filter can pass the sample straight through, vote over three samples, or vote over five samples. Because the vote is a majority over an odd count, the filtered level moves to a new value only when more than half of the window holds that value. An isolated noise spike therefore never reaches the output.

There are two ways to run it. In continuous mode the block samples on every cycle. It raises a valid flag once the window is full, and after that it presents a fresh vote on every cycle. In single-shot mode the block stays idle until a start strobe arrives. It then waits for a programmable settling interval, takes exactly as many samples as the window needs, and reports the vote with a one-cycle completion pulse. It holds that result until the next conversion completes. Changing the window size or the mode discards everything gathered so far.

Top module: `cmp_majority_filter`

## Requirements
- R1: The window select `flen_i` uses these codes: 0 means no filtering (window of 1), 1 means a window of 3 samples, and 2 means a window of 5 samples. Code 3 behaves exactly like code 2.
- R2: When a result is produced, `level_o` equals the majority value of the most recent N samples. For N=3 that takes 2 of 3 samples, and for N=5 it takes 3 of 5. A single sample that disagrees with its neighbours never changes `level_o`.
- R3: In continuous mode (`mode_i`=0), one sample of `raw_i` is taken at each rising edge, starting with the first edge after reset or after a configuration change. `valid_o` rises at the edge that takes the Nth sample, and `level_o` is updated at every edge from then on.
- R4: With no filtering, `level_o` equals the value of `raw_i` sampled at the previous rising edge (one register stage), and `valid_o` is high from the first sample on.
- R5: In single-shot mode (`mode_i`=1), a start strobe accepted at edge E with settling count S causes samples to be taken at edges E+S+1 through E+S+N. `done_o` is high for exactly one cycle after edge E+S+N, and `level_o` and `valid_o` carry the result from that point. `busy_o` is high from edge E until that same edge, and it is low whenever `done_o` is high.
- R6: During the S settling cycles (`startup_i`, 0 to 15) no sample is taken, so `raw_i` has no influence on the result during that time.
- R7: A start strobe that arrives while a single-shot conversion is busy is ignored. The completion timing and the result of the ongoing conversion are unchanged, and no extra conversion follows.
- R8: In single-shot mode, `level_o` changes only at the edge where `done_o` is raised, and `valid_o` stays high after the first completed conversion.
- R9: A change of `flen_i` or `mode_i` from one cycle to the next clears the sample history and the sample count, and it aborts any conversion. At the following edge `level_o`, `valid_o`, `done_o` and `busy_o` are all 0.
- R10: In continuous mode `start_i` is ignored. `busy_o` and `done_o` stay 0, and the filtered output is not disturbed.
- R11: After a synchronous reset, `level_o`, `valid_o`, `done_o` and `busy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | 1 | Raw comparator decision |
| flen_i | input | 2 | Window select: 0 none, 1 three samples, 2 or 3 five samples |
| mode_i | input | 1 | 0 continuous, 1 single-shot |
| start_i | input | 1 | Single-shot start strobe |
| startup_i | input | STARTUP_W | Settling cycles before the first single-shot sample |
| level_o | output | 1 | Filtered comparator level |
| valid_o | output | 1 | Filtered level is meaningful |
| done_o | output | 1 | One-cycle single-shot completion pulse |
| busy_o | output | 1 | Single-shot conversion in progress |

## Verification
Two events can fall on the same edge: the completion of a single-shot conversion and a new start strobe, or a configuration change. The bench drives a second start exactly on the edge where the last sample is taken and at points inside the settling interval. It then checks that `done_o` fires once, at the time set by the first start, and that `busy_o` drops with it. A mode change is also forced in the middle of a settling interval, and the bench checks that the block ends up idle and cleared rather than completing.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

    localparam int unsigned WIN_MAX = 5;
    localparam int unsigned CNT_W   = $clog2(WIN_MAX + 1);

    typedef enum logic [1:0] {
        FLEN_OFF  = 2'd0,
        FLEN_MAJ3 = 2'd1,
        FLEN_MAJ5 = 2'd2,
        FLEN_ALT5 = 2'd3
    } flen_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WAIT   = 2'd1,
        SEQ_SAMPLE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic level;
        logic valid;
        logic done;
    } result_t;

    // Window length in samples for a given select code.
    function automatic logic [CNT_W-1:0] win_len(input flen_e f);
        logic [CNT_W-1:0] n;
        case (f)
            FLEN_OFF:  n = CNT_W'(1);
            FLEN_MAJ3: n = CNT_W'(3);
            default:   n = CNT_W'(5);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cmpf_history.sv
module cmpf_history
    import cmpf_pkg::*;
#(
    parameter int unsigned DEPTH = WIN_MAX,
    parameter int unsigned CW    = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             launch,
    input  logic             shift,
    input  logic             bit_i,
    output logic [DEPTH-1:0] hist_nxt,
    output logic [CW-1:0]    cnt_nxt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [DEPTH-1:0] hist_q;
    logic [CW-1:0]    cnt_q;

    always_comb begin
        hist_nxt = hist_q;
        cnt_nxt  = cnt_q;
        if (shift) begin
            hist_nxt = {hist_q[DEPTH-2:0], bit_i};
            cnt_nxt  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr || launch) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else begin
            hist_q <= hist_nxt;
            cnt_q  <= cnt_nxt;
        end
    end
endmodule

// File: rtl/cmpf_vote.sv
module cmpf_vote
    import cmpf_pkg::*;
#(
    parameter int unsigned DEPTH = WIN_MAX,
    parameter int unsigned CW    = CNT_W
) (
    input  logic [DEPTH-1:0] hist,
    input  logic [CW-1:0]    len,
    output logic             maj
);
    logic [DEPTH-1:0] in_win;
    logic [CW-1:0]    ones;

    for (genvar g = 0; g < DEPTH; g++) begin : g_mask
        assign in_win[g] = hist[g] & (CW'(g) < len);
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ones = ones + CW'(in_win[i]);
        end
    end

    assign maj = {ones, 1'b0} > {1'b0, len};
endmodule

// File: rtl/cmpf_seq.sv
module cmpf_seq
    import cmpf_pkg::*;
#(
    parameter int unsigned SU_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            single,
    input  logic            start,
    input  logic [SU_W-1:0] startup,
    input  logic            reach,
    output logic            launch,
    output logic            sampling,
    output logic            busy
);
    seq_state_e      state_q;
    logic [SU_W-1:0] wait_q;

    assign launch   = single && start && (state_q == SEQ_IDLE) && !clr;
    assign sampling = (state_q == SEQ_SAMPLE);
    assign busy     = (state_q != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= SEQ_IDLE;
            wait_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (launch) begin
                        state_q <= (startup == '0) ? SEQ_SAMPLE : SEQ_WAIT;
                        wait_q  <= startup;
                    end
                end
                SEQ_WAIT: begin
                    if (wait_q == SU_W'(1)) state_q <= SEQ_SAMPLE;
                    wait_q <= wait_q - SU_W'(1);
                end
                SEQ_SAMPLE: begin
                    if (reach) state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmp_majority_filter.sv
module cmp_majority_filter
    import cmpf_pkg::*;
#(
    parameter int unsigned STARTUP_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 raw_i,
    input  logic [1:0]           flen_i,
    input  logic                 mode_i,
    input  logic                 start_i,
    input  logic [STARTUP_W-1:0] startup_i,
    output logic                 level_o,
    output logic                 valid_o,
    output logic                 done_o,
    output logic                 busy_o
);
    logic [1:0]       flen_q;
    logic             mode_q;
    logic             cfg_clr;
    logic [CNT_W-1:0] win;
    logic             launch, sampling, shift, reach, maj;
    logic [WIN_MAX-1:0] hist_nxt;
    logic [CNT_W-1:0]   cnt_nxt;
    result_t          res_q;

    // Configuration tracking: any change acts as a local clear.
    always_ff @(posedge clk) begin
        flen_q <= flen_i;
        mode_q <= mode_i;
    end

    assign cfg_clr = !rst && ((flen_i != flen_q) || (mode_i != mode_q));
    assign win     = win_len(flen_e'(flen_i));
    assign shift   = mode_i ? sampling : 1'b1;
    assign reach   = shift && (cnt_nxt >= win);

    cmpf_seq #(.SU_W(STARTUP_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (cfg_clr),
        .single   (mode_i),
        .start    (start_i),
        .startup  (startup_i),
        .reach    (reach),
        .launch   (launch),
        .sampling (sampling),
        .busy     (busy_o)
    );

    cmpf_history #(.DEPTH(WIN_MAX), .CW(CNT_W)) hist_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (cfg_clr),
        .launch   (launch),
        .shift    (shift),
        .bit_i    (raw_i),
        .hist_nxt (hist_nxt),
        .cnt_nxt  (cnt_nxt)
    );

    cmpf_vote #(.DEPTH(WIN_MAX), .CW(CNT_W)) vote_i (
        .hist (hist_nxt),
        .len  (win),
        .maj  (maj)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_clr) begin
            res_q <= '0;
        end else begin
            res_q.done <= 1'b0;
            if (reach) begin
                res_q.level <= maj;
                res_q.valid <= 1'b1;
                res_q.done  <= mode_i;
            end
        end
    end

    assign level_o = res_q.level;
    assign valid_o = res_q.valid;
    assign done_o  = res_q.done;
endmodule

// File: rtl/cmpf_checker.sv
module cmpf_checker (
    input logic clk,
    input logic rst,
    input logic mode_q,
    input logic cfg_clr,
    input logic level_o,
    input logic valid_o,
    input logic done_o,
    input logic busy_o
);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_clear_outputs_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_clr |=> (!valid_o && !level_o && !busy_o && !done_o));

    assert_cont_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !cfg_clr) |=> (!busy_o && !done_o));

    assert_single_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !cfg_clr) |=> (done_o || $stable(level_o)));
endmodule

bind cmp_majority_filter cmpf_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .mode_q  (mode_q),
    .cfg_clr (cfg_clr),
    .level_o (level_o),
    .valid_o (valid_o),
    .done_o  (done_o),
    .busy_o  (busy_o)
);

// File: tb/cmp_majority_filter_tb_top.sv
`timescale 1ns/1ps
module cmp_majority_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw = 1'b0;
    logic [1:0] flen = 2'd0;
    logic       mode = 1'b0;
    logic       start = 1'b0;
    logic [3:0] startup = 4'd0;
    logic       level, valid, done, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Reference window model
    logic [4:0] rh;
    int         rc;
    int         rn;
    logic       el, ev;

    always #2.5 clk = ~clk;

    cmp_majority_filter dut_i (
        .clk(clk), .rst(rst), .raw_i(raw), .flen_i(flen), .mode_i(mode),
        .start_i(start), .startup_i(startup),
        .level_o(level), .valid_o(valid), .done_o(done), .busy_o(busy)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic ref_maj(input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += int'(rh[i]);
        return (2 * c > n);
    endfunction

    task automatic model_clear();
        rh = '0; rc = 0; el = 1'b0; ev = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] f, input logic m, input int n);
        @(negedge clk);
        flen = f; mode = m; start = 1'b0; raw = 1'b0; rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        rn = n;
        model_clear();
    endtask

    task automatic cont_step(input logic b, input string tag);
        raw = b;
        tick();
        rh = {rh[3:0], b};
        rc++;
        if (rc >= rn) begin
            ev = 1'b1;
            el = ref_maj(rn);
        end
        check(tag, "valid", valid, ev);
        check(tag, "level", level, el);
    endtask

    task automatic test_reset_state();
        do_reset(2'd1, 1'b0, 3);
        check("R11", "level", level, 1'b0);
        check("R11", "valid", valid, 1'b0);
        check("R11", "done",  done,  1'b0);
        check("R11", "busy",  busy,  1'b0);
    endtask

    task automatic test_cont(input logic [1:0] f, input int n, input logic [15:0] pat,
                             input int len, input string tag);
        do_reset(f, 1'b0, n);
        for (int i = 0; i < len; i++) cont_step(pat[i], tag);
    endtask

    task automatic test_cont_start();
        do_reset(2'd2, 1'b0, 5);
        for (int i = 0; i < 8; i++) begin
            start = 1'b1;
            cont_step(i[1] ^ i[0], "R10");
            check("R10", "busy", busy, 1'b0);
            check("R10", "done", done, 1'b0);
        end
        start = 1'b0;
    endtask

    // Single-shot conversion; extra_at>=0 pulses a second start at that step index.
    task automatic ss_run(input int n, input int s, input logic [4:0] pat, input logic junk,
                          input logic exp, input int extra_at, input string tag);
        int step = 0;
        startup = 4'(s);
        start = 1'b1; raw = junk;
        tick();
        start = 1'b0;
        check(tag, "busy after start", busy, 1'b1);
        check(tag, "done after start", done, 1'b0);
        for (int i = 0; i < s; i++) begin
            raw = junk;
            start = (step == extra_at);
            step++;
            tick();
            start = 1'b0;
            check("R6", "busy in wait", busy, 1'b1);
            check("R6", "done in wait", done, 1'b0);
        end
        for (int i = 0; i < n; i++) begin
            raw = pat[i];
            start = (step == extra_at);
            step++;
            tick();
            start = 1'b0;
            if (i < n - 1) begin
                check(tag, "busy sampling", busy, 1'b1);
                check(tag, "done early", done, 1'b0);
            end else begin
                check(tag, "done", done, 1'b1);
                check(tag, "busy at done", busy, 1'b0);
                check(tag, "level", level, exp);
                check(tag, "valid", valid, 1'b1);
            end
        end
        raw = ~exp;
        tick();
        check("R8", "done pulse ends", done, 1'b0);
        check("R8", "level held", level, exp);
        check("R8", "valid held", valid, 1'b1);
        check("R7", "no extra conversion", busy, 1'b0);
    endtask

    task automatic test_single_basic();
        do_reset(2'd1, 1'b1, 3);
        ss_run(3, 0, 5'b00101, 1'b0, 1'b1, -1, "R5");
        do_reset(2'd2, 1'b1, 5);
        ss_run(5, 4, 5'b10110, 1'b0, 1'b1, -1, "R5");
        do_reset(2'd0, 1'b1, 1);
        ss_run(1, 2, 5'b00000, 1'b1, 1'b0, -1, "R6");
    endtask

    task automatic test_single_restart();
        do_reset(2'd2, 1'b1, 5);
        ss_run(5, 3, 5'b01011, 1'b0, 1'b1, 1, "R7");
        ss_run(5, 3, 5'b00100, 1'b1, 1'b0, 7, "R7");
    endtask

    task automatic test_hold();
        do_reset(2'd1, 1'b1, 3);
        ss_run(3, 1, 5'b00011, 1'b0, 1'b1, -1, "R8");
        for (int i = 0; i < 3; i++) begin
            raw = i[0];
            tick();
            check("R8", "idle level", level, 1'b1);
        end
        ss_run(3, 2, 5'b00001, 1'b1, 1'b0, -1, "R8");
    endtask

    task automatic test_clear();
        do_reset(2'd1, 1'b0, 3);
        for (int i = 0; i < 4; i++) cont_step(1'b1, "R9");
        flen = 2'd2;
        tick();
        check("R9", "valid after length change", valid, 1'b0);
        check("R9", "level after length change", level, 1'b0);
        rn = 5;
        model_clear();
        for (int i = 0; i < 6; i++) cont_step(1'b1, "R9");
        // Abort single-shot mid-settle via mode change
        do_reset(2'd1, 1'b1, 3);
        ss_run(3, 0, 5'b00111, 1'b0, 1'b1, -1, "R9");
        startup = 4'd4; start = 1'b1;
        tick();
        start = 1'b0;
        check("R9", "busy before abort", busy, 1'b1);
        mode = 1'b0;
        tick();
        check("R9", "busy after mode change", busy, 1'b0);
        check("R9", "valid after mode change", valid, 1'b0);
        check("R9", "level after mode change", level, 1'b0);
        model_clear();
        for (int i = 0; i < 4; i++) cont_step(1'b1, "R9");
    endtask

    initial begin
        test_reset_state();
        test_cont(2'd1, 3, 16'b1011_0111_0100_1101, 16, "R2");
        test_cont(2'd1, 3, 16'b1111_1110_1111_0111, 16, "R3");
        test_cont(2'd2, 5, 16'b1101_1110_0100_1011, 16, "R2");
        test_cont(2'd3, 5, 16'b0011_1011_0001_1100, 16, "R1");
        test_cont(2'd0, 1, 16'b0110_1001_1100_0101, 16, "R4");
        test_cont_start();
        test_single_basic();
        test_single_restart();
        test_hold();
        test_clear();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule